// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This unit turns an 80-bit extended-precision floating-point operand into a signed two's-complement integer. It always rounds toward zero and ignores any programmable rounding mode. The caller picks a destination of 16, 32 or 64 bits. The result always leaves the unit as a 64-bit word. For the narrower widths, that word is sign-extended from the selected width.

The operand layout is bit 79 sign, bits 78:64 a biased exponent (bias 16383), and bits 63:0 a significand whose top bit is the explicit integer bit. A caller presents a conversion with a one-cycle strobe. The caller also presents an indication that the source register is empty. One clock later the unit returns the integer together with invalid, stack-underflow and precision flags and a condition bit. Any invalid case produces the integer indefinite value, which has only the sign bit of the selected width set.

Top module: `fchop_unit`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle with `op_valid` high. Results, flags and condition bit are captured only on a strobe and hold their values otherwise.
- R2: `op_width` selects the destination: 2'b00 is 16 bits, 2'b01 is 32 bits, and 2'b10 or 2'b11 is 64 bits. An in-range result is the truncated value in 64-bit two's complement, which is its sign extension from the selected width.
- R3: Finite values with magnitude of at least 1 are truncated toward zero. `res_precision` is set exactly when nonzero fraction bits are discarded.
- R4: A zero, a denormal (exponent field 0) or any value with magnitude below 1 gives a result of 0. Precision is set when the significand is nonzero and clear for a true zero.
- R5: An exponent field of all ones (infinity or NaN) sets `res_invalid` and returns the indefinite value.
- R6: A truncated magnitude beyond the selected width sets `res_invalid`. A negative magnitude of exactly 2^(N-1) is valid, and the positive magnitude 2^(N-1) is invalid.
- R7: The indefinite value is 64'hFFFF_FFFF_FFFF_8000 for 16 bits, 64'hFFFF_FFFF_8000_0000 for 32 bits and 64'h8000_0000_0000_0000 for 64 bits. Whenever `res_invalid` is set, `res_precision` is clear.
- R8: With `op_empty` high, the operand is ignored. The unit sets `res_underflow` and `res_invalid` and returns the indefinite value. Without `op_empty`, `res_underflow` is clear.
- R9: `res_c1` is 0 on every completed conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Conversion request strobe |
| op_value | input | 80 | Extended-precision operand |
| op_width | input | 2 | Destination width select |
| op_empty | input | 1 | Source register is empty |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_data | output | 64 | Integer result, sign-extended |
| res_invalid | output | 1 | Invalid-operation flag |
| res_underflow | output | 1 | Stack-underflow flag |
| res_precision | output | 1 | Inexact (precision) flag |
| res_c1 | output | 1 | Condition bit C1 |

## Verification
The bench targets the edges of each range at every width, where an off-by-one range test hurts most. It converts -2^(N-1), 2^(N-1)-1 and 2^(N-1). A design that compared magnitudes symmetrically would reject the most negative integer, and one that was loose by one would let +2^(N-1) wrap to a negative number. It also checks fractions just below 1 and denormals, where a wrong shift would leave a stray 1 or lose the precision flag. Infinity, NaN and an empty source are checked as well, where a design that forgot the sign extension would return 0x8000 instead of the extended indefinite value. Idle cycles with changing inputs show whether the outputs leak through without a strobe.

// File: rtl/fchop_unit.sv
module fchop_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [79:0] op_value,
  input  logic [1:0]  op_width,
  input  logic        op_empty,
  output logic        res_valid,
  output logic [63:0] res_data,
  output logic        res_invalid,
  output logic        res_underflow,
  output logic        res_precision,
  output logic        res_c1
);
  localparam logic [14:0] BIAS = 15'd16383;

  logic        sgn;
  logic [14:0] ex;
  logic [63:0] man;
  logic [14:0] unb;
  logic [6:0]  pos;
  logic [63:0] mag, frac, lim, indef;
  logic [63:0] n_data;
  logic        n_inv, n_unf, n_prec;

  assign sgn  = op_value[79];
  assign ex   = op_value[78:64];
  assign man  = op_value[63:0];
  assign unb  = ex - BIAS;
  assign pos  = {1'b0, unb[5:0]};
  assign mag  = man >> (7'd63 - pos);
  assign frac = man << (pos + 7'd1);

  always_comb begin
    case (op_width)
      2'b00:   begin lim = 64'h0000_0000_0000_7FFF; indef = 64'hFFFF_FFFF_FFFF_8000; end
      2'b01:   begin lim = 64'h0000_0000_7FFF_FFFF; indef = 64'hFFFF_FFFF_8000_0000; end
      default: begin lim = 64'h7FFF_FFFF_FFFF_FFFF; indef = 64'h8000_0000_0000_0000; end
    endcase
  end

  always_comb begin
    n_data = '0;
    n_inv  = 1'b0;
    n_unf  = 1'b0;
    n_prec = 1'b0;
    if (op_empty) begin
      n_unf  = 1'b1;
      n_inv  = 1'b1;
      n_data = indef;
    end else if (ex == 15'h7FFF) begin
      n_inv  = 1'b1;
      n_data = indef;
    end else if (ex < BIAS) begin
      n_prec = |man;
    end else if (unb > 15'd63) begin
      n_inv  = 1'b1;
      n_data = indef;
    end else if (sgn ? (mag > lim + 64'd1) : (mag > lim)) begin
      n_inv  = 1'b1;
      n_data = indef;
    end else begin
      n_data = sgn ? (~mag + 64'd1) : mag;
      n_prec = |frac;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_data      <= '0;
      res_invalid   <= 1'b0;
      res_underflow <= 1'b0;
      res_precision <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data      <= n_data;
        res_invalid   <= n_inv;
        res_underflow <= n_unf;
        res_precision <= n_prec;
      end
    end
  end

  assign res_c1 = 1'b0;
endmodule

module fchop_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [79:0] op_value,
  input logic        op_empty,
  input logic        res_valid,
  input logic [63:0] res_data,
  input logic        res_invalid,
  input logic        res_underflow,
  input logic        res_precision
);
  a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data));
  a_r4_small_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_empty && op_value[78:64] < 15'd16383) |=> (res_data == 64'd0 && !res_invalid));
  a_r5_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_value[78:64] == 15'h7FFF) |=> res_invalid);
  a_r7_indef_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_invalid) |-> (res_data == 64'hFFFF_FFFF_FFFF_8000 ||
      res_data == 64'hFFFF_FFFF_8000_0000 || res_data == 64'h8000_0000_0000_0000));
  a_r7_inv_no_prec: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_invalid) |-> !res_precision);
  a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_empty) |=> (res_underflow && res_invalid));
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_empty) |=> !res_underflow);
endmodule

bind fchop_unit fchop_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_value(op_value),
  .op_empty(op_empty), .res_valid(res_valid), .res_data(res_data),
  .res_invalid(res_invalid), .res_underflow(res_underflow),
  .res_precision(res_precision)
);

// File: tb/sim_fchop_unit.sv
module sim_fchop_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [79:0] op_value = '0;
  logic [1:0]  op_width = 2'b00;
  logic        op_empty = 1'b0;
  logic        res_valid, res_invalid, res_underflow, res_precision, res_c1;
  logic [63:0] res_data;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fchop_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_value(op_value),
    .op_width(op_width), .op_empty(op_empty), .res_valid(res_valid),
    .res_data(res_data), .res_invalid(res_invalid), .res_underflow(res_underflow),
    .res_precision(res_precision), .res_c1(res_c1)
  );

  function automatic logic [79:0] fp(input logic s, input int unsigned e, input logic [63:0] m);
    return {s, e[14:0], m};
  endfunction

  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  task automatic conv(input string tag, input logic [79:0] x, input logic [1:0] w,
                      input logic emp, input logic [63:0] ed, input logic ei,
                      input logic eu, input logic ep);
    @(negedge clk);
    op_valid = 1'b1; op_value = x; op_width = w; op_empty = emp;
    @(negedge clk);
    op_valid = 1'b0;
    n_checks++;
    if (!(res_valid === 1'b1 && res_data === ed && res_invalid === ei &&
          res_underflow === eu && res_precision === ep && res_c1 === 1'b0)) begin
      n_fail++;
      $display("FAIL %s: got v=%b d=%h i=%b u=%b p=%b c1=%b expected v=1 d=%h i=%b u=%b p=%b c1=0",
               tag, res_valid, res_data, res_invalid, res_underflow, res_precision, res_c1,
               ed, ei, eu, ep);
    end
  endtask

  task automatic t_reset();
    n_checks++;
    if (res_valid !== 1'b0 || res_data !== 64'd0 || res_invalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%b d=%h i=%b expected v=0 d=0 i=0", res_valid, res_data, res_invalid);
    end
  endtask

  task automatic t_truncate();
    conv("R3 one", fp(0, 16383, ONE), 2'b10, 0, 64'd1, 0, 0, 0);
    conv("R3 2.75 w32", fp(0, 16384, 64'hB000_0000_0000_0000), 2'b01, 0, 64'd2, 0, 0, 1);
    conv("R2 R3 -2.75 w16", fp(1, 16384, 64'hB000_0000_0000_0000), 2'b00, 0,
         64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 1);
    conv("R3 large w64 inexact", fp(0, 16383 + 62, 64'hFFFF_FFFF_FFFF_FFFF), 2'b10, 0,
         64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 1);
    conv("R9 c1 after exact", fp(1, 16383 + 3, 64'hA000_0000_0000_0000), 2'b01, 0,
         64'hFFFF_FFFF_FFFF_FFF6, 0, 0, 0);
  endtask

  task automatic t_small();
    conv("R4 0.5", fp(0, 16382, ONE), 2'b00, 0, 64'd0, 0, 0, 1);
    conv("R4 -0.99", fp(1, 16382, 64'hFFFF_FFFF_FFFF_FFFF), 2'b10, 0, 64'd0, 0, 0, 1);
    conv("R4 zero", fp(0, 0, 64'd0), 2'b01, 0, 64'd0, 0, 0, 0);
    conv("R4 denormal", fp(1, 0, 64'd1), 2'b10, 0, 64'd0, 0, 0, 1);
  endtask

  task automatic t_special();
    conv("R5 R7 +inf w16", fp(0, 32767, ONE), 2'b00, 0, 64'hFFFF_FFFF_FFFF_8000, 1, 0, 0);
    conv("R5 R7 nan w32", fp(1, 32767, 64'hC000_0000_0000_0000), 2'b01, 0,
         64'hFFFF_FFFF_8000_0000, 1, 0, 0);
    conv("R5 -inf w64", fp(1, 32767, ONE), 2'b10, 0, 64'h8000_0000_0000_0000, 1, 0, 0);
  endtask

  task automatic t_range();
    conv("R6 32767 w16", fp(0, 16383 + 14, 64'hFFFE_0000_0000_0000), 2'b00, 0, 64'h7FFF, 0, 0, 0);
    conv("R6 +32768 w16", fp(0, 16383 + 15, ONE), 2'b00, 0, 64'hFFFF_FFFF_FFFF_8000, 1, 0, 0);
    conv("R6 R2 -32768 w16", fp(1, 16383 + 15, ONE), 2'b00, 0, 64'hFFFF_FFFF_FFFF_8000, 0, 0, 0);
    conv("R6 R7 32768.5 w16 inv no prec", fp(0, 16383 + 15, 64'h8000_8000_0000_0000), 2'b00, 0,
         64'hFFFF_FFFF_FFFF_8000, 1, 0, 0);
    conv("R6 -2^31 w32", fp(1, 16383 + 31, ONE), 2'b01, 0, 64'hFFFF_FFFF_8000_0000, 0, 0, 0);
    conv("R6 +2^31 w32", fp(0, 16383 + 31, ONE), 2'b01, 0, 64'hFFFF_FFFF_8000_0000, 1, 0, 0);
    conv("R6 -2^63 w64", fp(1, 16383 + 63, ONE), 2'b10, 0, 64'h8000_0000_0000_0000, 0, 0, 0);
    conv("R6 +2^63 w64", fp(0, 16383 + 63, ONE), 2'b10, 0, 64'h8000_0000_0000_0000, 1, 0, 0);
    conv("R6 -2^64 w64", fp(1, 16383 + 64, ONE), 2'b10, 0, 64'h8000_0000_0000_0000, 1, 0, 0);
  endtask

  task automatic t_width3();
    conv("R2 sel11 is 64", fp(0, 16383 + 40, ONE), 2'b11, 0, 64'h0000_0100_0000_0000, 0, 0, 0);
    conv("R2 same in w32", fp(0, 16383 + 40, ONE), 2'b01, 0, 64'hFFFF_FFFF_8000_0000, 1, 0, 0);
  endtask

  task automatic t_empty();
    conv("R8 empty w32", fp(0, 16383, ONE), 2'b01, 1, 64'hFFFF_FFFF_8000_0000, 1, 1, 0);
    conv("R8 empty w64 frac", fp(0, 16382, ONE), 2'b10, 1, 64'h8000_0000_0000_0000, 1, 1, 0);
  endtask

  task automatic t_idle();
    conv("R1 prime", fp(0, 16383 + 2, 64'hE000_0000_0000_0000), 2'b00, 0, 64'd7, 0, 0, 0);
    @(negedge clk);
    op_value = fp(0, 32767, ONE); op_width = 2'b01; op_empty = 1'b1;
    @(negedge clk);
    @(negedge clk);
    n_checks++;
    if (res_valid !== 1'b0 || res_data !== 64'd7 || res_invalid !== 1'b0 || res_underflow !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 hold: got v=%b d=%h i=%b u=%b expected v=0 d=7 i=0 u=0",
               res_valid, res_data, res_invalid, res_underflow);
    end
    op_empty = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_truncate();
    t_small();
    t_special();
    t_range();
    t_width3();
    t_empty();
    t_idle();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule